// File: doc/BRIEF.md
# Three-Share Threshold Nibble Substitution Unit

This unit applies a fixed 4-bit nonlinear substitution to a value that never appears in the clear. The value arrives as three 4-bit Boolean shares whose XOR is the real nibble, and the result leaves as three 4-bit shares whose XOR is the substituted nibble. Inside, the cubic substitution is split into two passes of one quadratic map. That map is wrapped in affine maps on the input and output side and in an affine re-map between the passes. Each quadratic pass is evaluated with a non-complete sharing: every result share is formed from only two of the three operand shares.

A single 8-input, 4-output share circuit does all of the nonlinear work. It runs once per share per pass, so a nibble takes six compute cycles. A rotation mux feeds the circuit, and two shift-style holding registers keep earlier share results until the third share of a pass is ready. A pulse on `start_i` while the unit is idle captures the three input shares. One cycle after the last compute cycle, `done_o` pulses with the result shares on the output ports. The result shares stay there until the next completion. No fresh randomness is added.

Control is a seven-state machine:
- `ST_IDLE` goes to `ST_P1_A` on `start_i`, or stays in `ST_IDLE`.
- The first-pass states run `ST_P1_A` to `ST_P1_B` to `ST_P1_C`, then to `ST_P2_A`.
- The second-pass states run `ST_P2_A` to `ST_P2_B` to `ST_P2_C`, then back to `ST_IDLE`.
- Every state other than `ST_IDLE` moves on without any condition.

Top module: `tis_sbox_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is low and all three result shares are 0 until the first completion.
- R2: A `start_i` sampled high on a clock edge while the unit is idle is accepted. `done_o` rises on the sixth rising edge after the accepting edge.
- R3: `done_o` is high for exactly one clock cycle per accepted start.
- R4: When `done_o` is high, the XOR of the three result shares equals S applied to the XOR of the three captured input shares. This holds for all 4096 share combinations. S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R5: The result shares change only on the edge that raises `done_o` and are otherwise held.
- R6: A `start_i` sampled on any edge from the accepting edge up to and including the edge that raises `done_o` is ignored. It produces no extra `done_o` pulse and does not alter the result in progress. A start on the next edge after that is accepted, so back-to-back nibbles take 7 cycles.
- R7: After acceptance the controller walks the six compute states in the fixed order first-pass A, B, C, then second-pass A, B, C, and then returns to idle.
- R8: The input shares are captured on the accepting edge. Changing them while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to substitute the presented shares |
| sh_a_i | input | 4 | Input share one |
| sh_b_i | input | 4 | Input share two |
| sh_c_i | input | 4 | Input share three |
| res_a_o | output | 4 | Result share one |
| res_b_o | output | 4 | Result share two |
| res_c_o | output | 4 | Result share three |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default affine constants, 1 on the input side and 5 on the output side. With those constants the shared result must reproduce the 16-entry table in R4. The defaults put every one of the 4096 share triples within reach. Each triple is started back to back, with starts held high through the busy window and the input ports scrambled during it. A behavioural cycle model compares the completion timing and the unshared result on every clock, and idle stretches probe the hold behaviour.

// File: rtl/tis_pkg.sv
package tis_pkg;
    localparam int NIB_W = 4;
    localparam int N_SHR = 3;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [N_SHR-1:0][NIB_W-1:0] shares_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1_A,
        ST_P1_B,
        ST_P1_C,
        ST_P2_A,
        ST_P2_B,
        ST_P2_C
    } phase_e;

    typedef enum logic [1:0] {
        AFF_IN,
        AFF_MID,
        AFF_OUT
    } aff_e;

    // Linear part applied before each pass.
    function automatic nib_t lin_pre(input nib_t v);
        return {v[3] ^ v[2], v[2] ^ v[1], v[1], v[2] ^ v[0]};
    endfunction

    // Inverse of lin_pre.
    function automatic nib_t lin_pre_inv(input nib_t v);
        return {v[3] ^ v[2] ^ v[1], v[2] ^ v[1], v[1], v[2] ^ v[1] ^ v[0]};
    endfunction

    // Linear part applied after the second pass.
    function automatic nib_t lin_post(input nib_t v);
        return {v[3] ^ v[1], v[2], v[3], v[3] ^ v[1] ^ v[0]};
    endfunction
endpackage

// File: rtl/tis_share_fn.sv
// Non-complete share of the quadratic map: result from shares j and k only.
module tis_share_fn
    import tis_pkg::*;
(
    input  nib_t pj_i,
    input  nib_t pk_i,
    output nib_t q_o
);
    logic xj, yj, zj, wj, xk, yk, zk, wk;

    always_comb begin
        {xj, yj, zj, wj} = pj_i;
        {xk, yk, zk, wk} = pk_i;
        q_o[3] = xj ^ (yj & zj) ^ (yj & zk) ^ (yk & zj)
                    ^ (yj & wj) ^ (yj & wk) ^ (yk & wj);
        q_o[2] = wj ^ (xj & yj) ^ (xj & yk) ^ (xk & yj);
        q_o[1] = yj;
        q_o[0] = zj ^ (yj & wj) ^ (yj & wk) ^ (yk & wj);
    end
endmodule

// File: rtl/tis_affine.sv
// Affine map over all shares; the constant lands on share 0 only.
module tis_affine
    import tis_pkg::*;
#(
    parameter aff_e KIND  = AFF_IN,
    parameter nib_t CONST = 4'h0
) (
    input  shares_t sh_i,
    output shares_t sh_o
);
    for (genvar i = 0; i < N_SHR; i++) begin : g_sh
        localparam nib_t K = (i == 0) ? CONST : '0;
        if (KIND == AFF_IN) begin : g_in
            assign sh_o[i] = lin_pre(sh_i[i]) ^ K;
        end else if (KIND == AFF_MID) begin : g_mid
            assign sh_o[i] = lin_pre_inv(sh_i[i] ^ K);
        end else begin : g_out
            assign sh_o[i] = lin_post(sh_i[i] ^ K);
        end
    end
endmodule

// File: rtl/tis_ctrl.sv
module tis_ctrl
    import tis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic [1:0] pick_o,
    output logic       load_in_o,
    output logic       load_mid_o,
    output logic       cap_o,
    output logic       wr_out_o
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_P1_A;
            ST_P1_A: state_d = ST_P1_B;
            ST_P1_B: state_d = ST_P1_C;
            ST_P1_C: state_d = ST_P2_A;
            ST_P2_A: state_d = ST_P2_B;
            ST_P2_B: state_d = ST_P2_C;
            ST_P2_C: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pick_o     = 2'd0;
        load_in_o  = 1'b0;
        load_mid_o = 1'b0;
        cap_o      = 1'b0;
        wr_out_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: load_in_o = start_i;
            ST_P1_A: begin pick_o = 2'd0; cap_o = 1'b1; end
            ST_P1_B: begin pick_o = 2'd1; cap_o = 1'b1; end
            ST_P1_C: begin pick_o = 2'd2; load_mid_o = 1'b1; end
            ST_P2_A: begin pick_o = 2'd0; cap_o = 1'b1; end
            ST_P2_B: begin pick_o = 2'd1; cap_o = 1'b1; end
            ST_P2_C: begin pick_o = 2'd2; wr_out_o = 1'b1; end
            default: ;
        endcase
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_P1_A));
    a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_P1_A));
    a_r7_p1_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P1_B) |=> (state_q == ST_P1_C));
    a_r7_pass_link: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P1_C) |=> (state_q == ST_P2_A));
    a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P2_C) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tis_sbox_unit.sv
module tis_sbox_unit
    import tis_pkg::*;
#(
    parameter logic [3:0] IN_CONST  = 4'h1,
    parameter logic [3:0] OUT_CONST = 4'h5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [3:0] sh_a_i,
    input  logic [3:0] sh_b_i,
    input  logic [3:0] sh_c_i,
    output logic [3:0] res_a_o,
    output logic [3:0] res_b_o,
    output logic [3:0] res_c_o,
    output logic       done_o
);
    logic [1:0] pick;
    logic       load_in, load_mid, cap, wr_out;

    shares_t op_q, op_src, op_d;
    shares_t mid_sh, out_sh, pass_sh;
    shares_t res_q;
    nib_t    hold_a_q, hold_b_q;
    nib_t    opj, opk, fq;
    logic    done_q;

    tis_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .pick_o    (pick),
        .load_in_o (load_in),
        .load_mid_o(load_mid),
        .cap_o     (cap),
        .wr_out_o  (wr_out)
    );

    // Shares of the finished pass: oldest in hold_b, newest from the circuit.
    assign pass_sh = {fq, hold_a_q, hold_b_q};

    tis_affine #(.KIND(AFF_MID), .CONST(IN_CONST)) u_mid (
        .sh_i(pass_sh), .sh_o(mid_sh));
    tis_affine #(.KIND(AFF_OUT), .CONST(OUT_CONST)) u_out (
        .sh_i(pass_sh), .sh_o(out_sh));

    assign op_src = load_in ? {sh_c_i, sh_b_i, sh_a_i} : mid_sh;

    tis_affine #(.KIND(AFF_IN), .CONST(IN_CONST)) u_in (
        .sh_i(op_src), .sh_o(op_d));

    // Rotation: result share i is fed the two other operand shares.
    always_comb begin
        unique case (pick)
            2'd0:    begin opj = op_q[1]; opk = op_q[2]; end
            2'd1:    begin opj = op_q[2]; opk = op_q[0]; end
            default: begin opj = op_q[0]; opk = op_q[1]; end
        endcase
    end

    tis_share_fn u_fn (.pj_i(opj), .pk_i(opk), .q_o(fq));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            hold_a_q <= '0;
            hold_b_q <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            if (load_in || load_mid) op_q <= op_d;
            if (cap) begin
                hold_b_q <= hold_a_q;
                hold_a_q <= fq;
            end
            if (wr_out) res_q <= out_sh;
            done_q <= wr_out;
        end
    end

    assign res_a_o = res_q[0];
    assign res_b_o = res_q[1];
    assign res_c_o = res_q[2];
    assign done_o  = done_q;

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({res_a_o, res_b_o, res_c_o}));
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (!done_o && res_a_o == 4'h0 && res_b_o == 4'h0 && res_c_o == 4'h0));
endmodule

// File: tb/tis_sbox_unit_tb.sv
module tis_sbox_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] sa = 4'h0, sb = 4'h0, sc = 4'h0;
    logic [3:0] ra, rb, rc;
    logic done;

    int checks = 0;
    int errors = 0;

    // model state
    int         cnt = 0;
    logic       exp_done = 1'b0;
    logic [3:0] pend = 4'h0;
    logic [3:0] exp_val = 4'h0;
    logic [11:0] prev_res = 12'h0;

    always #10 clk = ~clk;

    tis_sbox_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .sh_a_i(sa), .sh_b_i(sb), .sh_c_i(sc),
        .res_a_o(ra), .res_b_o(rb), .res_c_o(rc), .done_o(done));

    function automatic logic [3:0] sref(input logic [3:0] v);
        case (v)
            4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
            4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
            4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
            4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [11:0] act, input logic [11:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    // One clock: advance the model with the inputs present at the edge, then compare.
    task automatic tick();
        logic st;
        logic [3:0] x;
        st = start;
        x  = sa ^ sb ^ sc;
        @(posedge clk);
        exp_done = (cnt == 1);
        if (cnt > 0) cnt--;
        else if (st) begin cnt = 6; pend = sref(x); end
        if (exp_done) exp_val = pend;
        #2;
        chk(done == exp_done, "R2 R3 R6 done timing", {11'b0, done}, {11'b0, exp_done});
        if (exp_done)
            chk((ra ^ rb ^ rc) == exp_val, "R4 R8 unshared result", {8'b0, ra ^ rb ^ rc}, {8'b0, exp_val});
        else
            chk({rc, rb, ra} == prev_res, "R5 result held", {rc, rb, ra}, prev_res);
        prev_res = {rc, rb, ra};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!done && {ra, rb, rc} == 12'h0, "R1 reset state", {ra, rb, rc}, 12'h0);
        rst_n = 1'b1;
        tick();
        chk(!done && {ra, rb, rc} == 12'h0, "R1 after release", {ra, rb, rc}, 12'h0);

        // Exhaustive triples; starts held high and inputs scrambled while busy (R6, R8).
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 16; c++) begin
                    sa = a[3:0]; sb = b[3:0]; sc = c[3:0]; start = 1'b1;
                    tick();
                    for (int k = 0; k < 6; k++) begin
                        sa = sa + 4'h7; sb = sb ^ 4'h9; sc = ~sc;
                        start = (k != 2);
                        tick();
                    end
                end
            end
        end

        // Idle stretch with no start: outputs held (R5), no spurious done (R3).
        start = 1'b0;
        repeat (10) tick();

        // Single starts with gaps and a busy restart attempt (R6, R7 ordering via timing).
        sa = 4'h3; sb = 4'hA; sc = 4'h6; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (3) tick();
        sa = 4'hF; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (6) tick();
        chk(cnt == 0, "R7 six-state walk completed", 12'(cnt), 12'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule